// File: doc/BRIEF.md
# One-Dimensional Copy and Fill Engine

This block is the transfer datapath of a single DMA channel. Once a channel controller has set up its configuration inputs and pulsed `start`, the engine moves a run of elements over a word-wide memory port. In copy mode each element is read from a source address and then written to a destination address. In fill mode only destination writes happen, and each one carries a fill byte replicated across the enabled lanes.

Each element is 2^N bytes, with N taken from the control word. The source and destination element counts are each split into a low 16-bit half and a high 16-bit half, held in two size words. The remaining destination count is brought out live, so the controller can report residue while the transfer runs. The byte residue is that count shifted left by N.

The memory port uses a plain request/response handshake. The engine holds a request stable until the response arrives, and that response can flag an error.

Top module: `dma1d_engine`

## Requirements
- R1: After reset `busy`, `done`, `error` and `mem_req` are 0 and `rem_dst` is 0.
- R2: In copy mode (control bits 11:9 = 1) each element is read at the source address, taken from byte lane `src_addr % 4`, and written at the destination address in lane `dst_addr % 4`. The element size is 2^(control bits 2:0) bytes, and `mem_be` enables exactly those lanes.
- R3: After each element, the source address advances by the source increment (`cfg_inc` bits 15:0) times the element size. The destination address advances by the destination increment (`cfg_inc` bits 31:16) times the element size. The two advance independently.
- R4: In fill mode (control bits 11:9 = 3) no read request is issued. Every destination write carries `cfg_fill` in every byte lane.
- R5: The destination count is {`cfg_size_hi`[31:16], `cfg_size`[31:16]} and the source count is {`cfg_size_hi`[15:0], `cfg_size`[15:0]}. The destination count sets the number of writes. In copy mode, once the source count is used up, the remaining writes carry the fill byte and issue no reads.
- R6: `rem_dst` holds the full loaded destination count after start. It drops by one on each successful destination write response.
- R7: A start with a destination count of zero issues no memory request and ends in the next cycle, with `done` raised according to R8.
- R8: `done` pulses for one cycle at the end of a transfer when the done-type field (control bits 23:21) is 1 or 3. It stays low when that field is 0.
- R9: An error response ends the transfer. It pulses `error` for one cycle, never raises `done`, and leaves `rem_dst` frozen at the count of destination elements not yet written.
- R10: A start is ignored (no request, `busy` stays 0) when the transfer type is 0 or 2, or when the element size exceeds the data word.
- R11: While a request waits for its response, `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Start pulse for the configured transfer |
| cfg_ctrl | input | 32 | Control: size 2:0, type 11:9, done type 23:21 |
| cfg_src_addr | input | AW | Source byte address |
| cfg_dst_addr | input | AW | Destination byte address |
| cfg_size | input | 32 | Low halves: destination 31:16, source 15:0 |
| cfg_size_hi | input | 32 | High halves: destination 31:16, source 15:0 |
| cfg_inc | input | 32 | Increments in elements: destination 31:16, source 15:0 |
| cfg_fill | input | 8 | Fill byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| error | output | 1 | One-cycle error pulse |
| rem_dst | output | 32 | Remaining destination element count |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address of the request |
| mem_be | output | DW/8 | Byte-lane enables for writes |
| mem_wdata | output | DW | Write data |
| mem_rvalid | input | 1 | Response for the pending request |
| mem_rdata | input | DW | Read data |
| mem_rerr | input | 1 | Error flag on the response |

## Verification
The response to the last destination write does three things in one cycle: it decrements the remaining count, ends the transfer and decides the done pulse. An error response arriving in that same cycle must win, leaving the count at one and raising only `error`. The bench provokes this by marking the final destination word as faulting, and also marks a source word partway through a copy as faulting. In both cases it compares the frozen `rem_dst`, `error` and `done` with values worked out from the element index at which the fault hits.

// File: rtl/dma1d_pkg.sv
package dma1d_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RD   = 2'd1,
      ST_WR   = 2'd2
   } eng_state_e;

   localparam logic [2:0] XT_OFF  = 3'd0;
   localparam logic [2:0] XT_COPY = 3'd1;
   localparam logic [2:0] XT_WRAP = 3'd2;
   localparam logic [2:0] XT_FILL = 3'd3;

   localparam logic [2:0] DT_NONE  = 3'd0;
   localparam logic [2:0] DT_CMD   = 3'd1;
   localparam logic [2:0] DT_CYCLE = 3'd3;

   localparam int CNT_W  = 32;
   localparam int HALF_W = 16;

endpackage

// File: rtl/dma1d_walker.sv
module dma1d_walker #(
   parameter int AW = 16,
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          step,
   input  logic [AW-1:0] load_addr,
   input  logic [CW-1:0] load_cnt,
   input  logic [15:0]   load_inc,
   input  logic [2:0]    load_tsz,
   output logic [AW-1:0] addr,
   output logic [CW-1:0] cnt
);

   logic [AW-1:0] stride_q;
   logic [AW-1:0] stride_d;

   assign stride_d = AW'(load_inc) << load_tsz;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr     <= '0;
         cnt      <= '0;
         stride_q <= '0;
      end else if (load) begin
         addr     <= load_addr;
         cnt      <= load_cnt;
         stride_q <= stride_d;
      end else if (step) begin
         addr <= addr + stride_q;
         cnt  <= cnt - CW'(1);
      end
   end

   // R5: a walker is never stepped once its count is exhausted
   a_r5_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> cnt != '0);

endmodule

// File: rtl/dma1d_lanes.sv
module dma1d_lanes #(
   parameter int DW = 32
) (
   input  logic [2:0]              tsz,
   input  logic [$clog2(DW/8)-1:0] rd_lane,
   input  logic [$clog2(DW/8)-1:0] wr_lane,
   input  logic [DW-1:0]           rdata,
   input  logic [DW-1:0]           elem,
   input  logic [7:0]              fill,
   input  logic                    use_fill,
   output logic [DW-1:0]           elem_d,
   output logic [DW-1:0]           wdata,
   output logic [DW/8-1:0]         be
);

   localparam int LANES = DW / 8;
   localparam int LW    = $clog2(LANES);

   logic [DW-1:0]    placed;
   logic [LANES-1:0] mask;

   assign elem_d = rdata >> {rd_lane, 3'b000};
   assign placed = elem << {wr_lane, 3'b000};
   assign mask   = LANES'((64'd1 << (1 << tsz)) - 64'd1);
   assign be     = mask << wr_lane;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign wdata[g*8 +: 8] = use_fill ? fill : placed[g*8 +: 8];
   end

   initial begin
      a_lane_cfg: assert (LW >= 1 && (1 << LW) == LANES)
         else $fatal(1, "lane count must be a power of two of at least 2");
   end

endmodule

// File: rtl/dma1d_engine.sv
module dma1d_engine
   import dma1d_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic [31:0]     cfg_ctrl,
   input  logic [AW-1:0]   cfg_src_addr,
   input  logic [AW-1:0]   cfg_dst_addr,
   input  logic [31:0]     cfg_size,
   input  logic [31:0]     cfg_size_hi,
   input  logic [31:0]     cfg_inc,
   input  logic [7:0]      cfg_fill,
   output logic            busy,
   output logic            done,
   output logic            error,
   output logic [31:0]     rem_dst,
   output logic            mem_req,
   output logic            mem_we,
   output logic [AW-1:0]   mem_addr,
   output logic [DW/8-1:0] mem_be,
   output logic [DW-1:0]   mem_wdata,
   input  logic            mem_rvalid,
   input  logic [DW-1:0]   mem_rdata,
   input  logic            mem_rerr
);

   localparam int LANES = DW / 8;
   localparam int LW    = $clog2(LANES);

   initial begin
      a_cfg_widths: assert (DW % 8 == 0 && AW > LW && LANES <= 8)
         else $fatal(1, "unsupported data or address width");
   end

   eng_state_e  state_q;
   logic [2:0]  tsz_q;
   logic        fill_mode_q;
   logic        done_en_q;
   logic [7:0]  fill_q;
   logic        use_fill_q;
   logic        done_q;
   logic        error_q;
   logic [DW-1:0] elem_q;
   logic [DW-1:0] elem_d;

   logic [2:0]  c_tsz;
   logic [2:0]  c_xt;
   logic [2:0]  c_dt;
   logic        type_ok;
   logic        start_ok;
   logic [CNT_W-1:0] s_init;
   logic [CNT_W-1:0] d_init;
   logic        src_step;
   logic        dst_step;
   logic [AW-1:0]    src_addr;
   logic [AW-1:0]    dst_addr;
   logic [CNT_W-1:0] src_cnt;
   logic [CNT_W-1:0] dst_cnt;

   assign c_tsz    = cfg_ctrl[2:0];
   assign c_xt     = cfg_ctrl[11:9];
   assign c_dt     = cfg_ctrl[23:21];
   assign type_ok  = (c_xt == XT_COPY || c_xt == XT_FILL) && (c_tsz <= 3'(LW));
   assign start_ok = start && (state_q == ST_IDLE) && type_ok;
   assign s_init   = {cfg_size_hi[HALF_W-1:0], cfg_size[HALF_W-1:0]};
   assign d_init   = {cfg_size_hi[31:HALF_W], cfg_size[31:HALF_W]};
   assign src_step = (state_q == ST_RD) && mem_rvalid && !mem_rerr;
   assign dst_step = (state_q == ST_WR) && mem_rvalid && !mem_rerr;

   dma1d_walker #(.AW(AW), .CW(CNT_W)) i_src_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .step      (src_step),
      .load_addr (cfg_src_addr),
      .load_cnt  (s_init),
      .load_inc  (cfg_inc[15:0]),
      .load_tsz  (c_tsz),
      .addr      (src_addr),
      .cnt       (src_cnt)
   );

   dma1d_walker #(.AW(AW), .CW(CNT_W)) i_dst_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (start_ok),
      .step      (dst_step),
      .load_addr (cfg_dst_addr),
      .load_cnt  (d_init),
      .load_inc  (cfg_inc[31:16]),
      .load_tsz  (c_tsz),
      .addr      (dst_addr),
      .cnt       (dst_cnt)
   );

   dma1d_lanes #(.DW(DW)) i_lanes (
      .tsz      (tsz_q),
      .rd_lane  (src_addr[LW-1:0]),
      .wr_lane  (dst_addr[LW-1:0]),
      .rdata    (mem_rdata),
      .elem     (elem_q),
      .fill     (fill_q),
      .use_fill (use_fill_q),
      .elem_d   (elem_d),
      .wdata    (mem_wdata),
      .be       (mem_be)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         tsz_q       <= '0;
         fill_mode_q <= 1'b0;
         done_en_q   <= 1'b0;
         fill_q      <= '0;
         use_fill_q  <= 1'b0;
         elem_q      <= '0;
         done_q      <= 1'b0;
         error_q     <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         error_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  tsz_q       <= c_tsz;
                  fill_mode_q <= (c_xt == XT_FILL);
                  done_en_q   <= (c_dt == DT_CMD) || (c_dt == DT_CYCLE);
                  fill_q      <= cfg_fill;
                  if (d_init == '0) begin
                     done_q <= (c_dt == DT_CMD) || (c_dt == DT_CYCLE);
                  end else if (c_xt == XT_COPY && s_init != '0) begin
                     state_q <= ST_RD;
                  end else begin
                     state_q    <= ST_WR;
                     use_fill_q <= 1'b1;
                  end
               end
            end
            ST_RD: begin
               if (mem_rvalid) begin
                  if (mem_rerr) begin
                     error_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end else begin
                     elem_q     <= elem_d;
                     use_fill_q <= 1'b0;
                     state_q    <= ST_WR;
                  end
               end
            end
            ST_WR: begin
               if (mem_rvalid) begin
                  if (mem_rerr) begin
                     error_q <= 1'b1;
                     state_q <= ST_IDLE;
                  end else if (dst_cnt == CNT_W'(1)) begin
                     done_q  <= done_en_q;
                     state_q <= ST_IDLE;
                  end else if (!fill_mode_q && src_cnt != '0) begin
                     state_q <= ST_RD;
                  end else begin
                     use_fill_q <= 1'b1;
                     state_q    <= ST_WR;
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign error    = error_q;
   assign rem_dst  = dst_cnt;
   assign mem_req  = (state_q != ST_IDLE);
   assign mem_we   = (state_q == ST_WR);
   assign mem_addr = (state_q == ST_RD) ? src_addr : dst_addr;

   // R11: pending request held until its response
   a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_rvalid |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata));

   // R4: fill transfers never read
   a_r4_fill_no_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && fill_mode_q |-> mem_we);

   // R2: write lanes match the element size
   a_r2_be_width: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> $countones(mem_be) == (1 << tsz_q));

   // R6: a good write response consumes exactly one destination element
   a_r6_rem_step: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_rvalid && !mem_rerr |=> rem_dst == $past(rem_dst) - 32'd1);

   // R9: error freezes the count and excludes done
   a_r9_err_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      error |-> !done && !busy && rem_dst == $past(rem_dst));

   // R7: zero count issues no access
   a_r7_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      start_ok && d_init == '0 |=> !mem_req);

   // R10: rejected start leaves the engine idle
   a_r10_reject: assert property (@(posedge clk) disable iff (!rst_n)
      start && !busy && !type_ok |=> !busy);

endmodule

// File: tb/test_dma1d_engine.sv
module test_dma1d_engine;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int DW = 32;

   typedef struct {
      logic [15:0] addr;
      logic [3:0]  be;
      logic [31:0] data;
      logic [31:0] rem;
   } wr_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [31:0] cfg_ctrl = '0;
   logic [AW-1:0] cfg_src_addr = '0;
   logic [AW-1:0] cfg_dst_addr = '0;
   logic [31:0] cfg_size = '0;
   logic [31:0] cfg_size_hi = '0;
   logic [31:0] cfg_inc = '0;
   logic [7:0]  cfg_fill = '0;
   logic busy, done, error;
   logic [31:0] rem_dst;
   logic mem_req, mem_we;
   logic [AW-1:0] mem_addr;
   logic [3:0] mem_be;
   logic [31:0] mem_wdata;
   logic mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic mem_rerr = 1'b0;

   logic [31:0] mem [256];
   int err_word = -1;
   int checks = 0;
   int fails = 0;
   int req_cycles = 0;
   bit fill_run = 1'b0;
   wr_item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma1d_engine #(.AW(AW), .DW(DW)) i_dma1d_engine (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_ctrl(cfg_ctrl),
      .cfg_src_addr(cfg_src_addr), .cfg_dst_addr(cfg_dst_addr),
      .cfg_size(cfg_size), .cfg_size_hi(cfg_size_hi), .cfg_inc(cfg_inc),
      .cfg_fill(cfg_fill), .busy(busy), .done(done), .error(error),
      .rem_dst(rem_dst), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // memory model: one response per request, a cycle after it is seen
   always @(posedge clk) begin
      if (!rst_n) begin
         mem_rvalid <= 1'b0;
         mem_rerr   <= 1'b0;
      end else if (mem_rvalid) begin
         mem_rvalid <= 1'b0;
         mem_rerr   <= 1'b0;
      end else if (mem_req) begin
         mem_rvalid <= 1'b1;
         if (int'(mem_addr[9:2]) == err_word) begin
            mem_rerr <= 1'b1;
         end else begin
            mem_rerr  <= 1'b0;
            mem_rdata <= mem[mem_addr[9:2]];
            if (mem_we) begin
               for (int b = 0; b < 4; b++)
                  if (mem_be[b]) mem[mem_addr[9:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
            end
         end
      end
   end

   // monitor: scoreboard of destination writes
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req) req_cycles++;
         if (fill_run && mem_req && !mem_we)
            chk(1'b0, "R4", "read during fill", {16'b0, mem_addr}, 32'hffff_ffff);
         if (mem_req && mem_we && mem_rvalid && !mem_rerr) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R2", "unexpected write", {16'b0, mem_addr}, 32'hffff_ffff);
            end else begin
               wr_item_t e;
               logic [31:0] m;
               e = exp_q.pop_front();
               m = {{8{e.be[3]}}, {8{e.be[2]}}, {8{e.be[1]}}, {8{e.be[0]}}};
               chk(mem_addr == e.addr, "R3", "write address", {16'b0, mem_addr}, {16'b0, e.addr});
               chk(mem_be == e.be, "R2", "byte enables", {28'b0, mem_be}, {28'b0, e.be});
               chk((mem_wdata & m) == (e.data & m), "R2", "write data",
                   mem_wdata & m, e.data & m);
               chk(rem_dst == e.rem, "R6", "live remaining count", rem_dst, e.rem);
            end
         end
      end
   end

   // driver: computes expected writes, runs one transfer, judges the ending
   task automatic run(input string tag, input int xt, input int tsz, input int dt,
                      input int src, input int dst, input int ns, input int nd,
                      input int sinc, input int dinc, input logic [7:0] fill,
                      input int errw);
      bit ok_type;
      bit exp_err;
      logic [31:0] exp_rem;
      int sa, da, s;
      logic [31:0] elem;
      int cyc;
      ok_type = (xt == 1 || xt == 3) && tsz <= 2;
      exp_err = 1'b0;
      exp_rem = 32'(nd);
      sa = src; da = dst; s = ns;
      elem = '0;
      if (ok_type) begin
         for (int e = 0; e < nd; e++) begin
            bit uf;
            wr_item_t it;
            exp_rem = 32'(nd - e);
            uf = (xt == 3) || (s == 0);
            if (!uf) begin
               if (((sa >> 2) & 255) == errw) begin exp_err = 1'b1; break; end
               elem = mem[(sa >> 2) & 255] >> ((sa % 4) * 8);
               s--;
               sa += sinc << tsz;
            end
            if (((da >> 2) & 255) == errw) begin exp_err = 1'b1; break; end
            it.addr = 16'(da);
            it.be   = 4'(((1 << (1 << tsz)) - 1) << (da % 4));
            it.data = uf ? {4{fill}} : (elem << ((da % 4) * 8));
            it.rem  = 32'(nd - e);
            exp_q.push_back(it);
            da += dinc << tsz;
         end
         if (!exp_err) exp_rem = '0;
      end
      @(negedge clk);
      err_word     = errw;
      fill_run     = (xt == 3);
      req_cycles   = 0;
      cfg_ctrl     = {8'b0, 3'(dt), 9'b0, 3'(xt), 6'b0, 3'(tsz)};
      cfg_src_addr = 16'(src);
      cfg_dst_addr = 16'(dst);
      cfg_size     = {16'(nd), 16'(ns)};
      cfg_size_hi  = {16'(nd >> 16), 16'(ns >> 16)};
      cfg_inc      = {16'(dinc), 16'(sinc)};
      cfg_fill     = fill;
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (busy && cyc < 2000) begin
         @(negedge clk);
         cyc++;
      end
      chk(done == (ok_type && !exp_err && (dt == 1 || dt == 3)),
          exp_err ? "R9" : "R8", {tag, " done"}, {31'b0, done},
          {31'b0, ok_type && !exp_err && (dt == 1 || dt == 3)});
      chk(error == exp_err, "R9", {tag, " error"}, {31'b0, error}, {31'b0, exp_err});
      if (ok_type)
         chk(rem_dst == exp_rem, exp_err ? "R9" : "R6", {tag, " final count"}, rem_dst, exp_rem);
      chk(exp_q.size() == 0, "R2", {tag, " writes outstanding"}, 32'(exp_q.size()), 32'd0);
      exp_q.delete();
      if (!ok_type) begin
         repeat (4) @(negedge clk);
         chk(req_cycles == 0 && !busy, "R10", {tag, " rejected start"}, 32'(req_cycles), 32'd0);
      end
      if (ok_type && nd == 0)
         chk(req_cycles == 0, "R7", {tag, " zero count access"}, 32'(req_cycles), 32'd0);
      @(negedge clk);
      chk(!done && !error, "R8", {tag, " pulse width"}, {30'b0, done, error}, 32'd0);
      err_word = -1;
      fill_run = 1'b0;
   endtask

   initial begin
      for (int i = 0; i < 256; i++)
         mem[i] = {8'(i) ^ 8'h3c, 8'(i), ~8'(i), 8'(i) + 8'h11};
      repeat (3) @(negedge clk);
      chk(!busy && !done && !error && !mem_req && rem_dst == 0, "R1", "reset state",
          {28'b0, busy, done, error, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !mem_req && rem_dst == 0, "R1", "idle after reset",
          rem_dst, 32'd0);

      run("word copy R2",        1, 2, 1, 'h000, 'h200, 4, 4, 1, 1, 8'h00, -1);
      run("byte copy stride R3", 1, 0, 3, 'h041, 'h283, 6, 6, 1, 2, 8'h00, -1);
      run("word copy sinc2 R3",  1, 2, 1, 'h010, 'h240, 3, 3, 2, 1, 8'h00, -1);
      run("half fill R4",        3, 1, 1, 'h000, 'h302, 0, 5, 0, 1, 8'h5a, -1);
      run("zero count R7",       1, 2, 1, 'h000, 'h200, 0, 0, 1, 1, 8'h00, -1);
      run("type off R10",        0, 2, 1, 'h000, 'h200, 2, 2, 1, 1, 8'h00, -1);
      run("type wrap R10",       2, 2, 1, 'h000, 'h200, 2, 2, 1, 1, 8'h00, -1);
      run("size too big R10",    1, 3, 1, 'h000, 'h200, 2, 2, 1, 1, 8'h00, -1);
      run("no done type R8",     1, 2, 0, 'h020, 'h260, 2, 2, 1, 1, 8'h00, -1);
      run("pad after source R5", 1, 2, 1, 'h030, 'h380, 2, 4, 1, 1, 8'hc3, -1);
      run("read error R9",       1, 2, 1, 'h100, 'h3a0, 4, 4, 1, 1, 8'h00, 'h108 >> 2);
      run("last write error R9", 1, 2, 1, 'h120, 'h3c0, 3, 3, 1, 1, 8'h00, 'h3c8 >> 2);
      run("high count R5",       1, 2, 1, 'h140, 'h3e0, 1, 'h10003, 1, 1, 8'h00, 'h3e0 >> 2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule